// File: doc/BRIEF.md
# Unaligned IO Fragment to 16-bit Bus Cycle Sequencer

The block takes one IO-space access fragment and converts it into the smallest correct series of 16-bit bus data cycles. A fragment has a byte-resolution address, a length of one, two or three bytes, a direction flag, and right-aligned write data. The block then drives a plain cycle-request interface one cycle at a time. Each cycle carries an address, a byte-or-word select, a direction and write data. Each cycle completes on an acknowledge, and read cycles return a 16-bit word.

Reads on the target bus can have side effects. For that reason the block issues exactly the cycles each offset/length case needs and never more. It never fakes a byte write with a word read-modify-write. Reads are always word cycles, and the returned words are placed within a 32-bit result for the requester to extract bytes from.

A one-clock done strobe marks a completed fragment. A bus timeout abandons the fragment and raises a one-clock error strobe instead.

Top module: `qfrag_seq`

## Requirements
- R1: After reset, busy, busReq, doneStb and errStb are all low.
- R2: A read whose length plus address bit 0 is at most 2 issues exactly one word read at the address with bit 0 cleared. The returned word lands in rdData[31:16] when address bit 1 is set, and in rdData[15:0] otherwise, with the other half zero.
- R3: Any other read issues exactly two word reads, first at E and then at E+2, where E is the address with bit 0 cleared. The result is rdData = {second word, first word}.
- R4: Every read cycle is a word cycle (busByte = 0) with an even busAddr. Every word cycle presents an even address.
- R5: A one-byte write is exactly one byte cycle at the address, with busWdata = {8'h00, data[7:0]}.
- R6: A two-byte write at an even address is one word cycle carrying data[15:0]. At an odd address it is a byte cycle at A carrying data[7:0], then a byte cycle at A+1 carrying data[15:8].
- R7: A three-byte write at an odd address A is a byte cycle at A carrying data[7:0], then a word cycle at A+1 carrying data[23:8].
- R8: A three-byte write at an even address A is a word cycle at A carrying data[15:0], then a byte cycle at A+2 carrying data[23:16].
- R9: Once busReq is raised, it stays high with address, select, direction and data unchanged until busAck or busTimeout. The next cycle starts only after an acknowledge.
- R10: doneStb is high for exactly one clock, the clock after the final cycle's acknowledge. For reads, rdData is valid from that clock on.
- R11: busTimeout during a cycle ends the fragment. errStb pulses for one clock, no further cycle is issued and doneStb is not raised.
- R12: reqValid is ignored while busy. A fragment never produces more than two bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Fragment present; taken when not busy |
| reqAddr | input | ADDR_W | Byte address of the fragment |
| reqLen | input | 2 | Length in bytes, 1 to 3 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 24 | Right-aligned write data |
| busy | output | 1 | Fragment in progress |
| doneStb | output | 1 | One-clock completion strobe |
| errStb | output | 1 | One-clock timeout-abort strobe |
| rdData | output | 32 | Assembled read result |
| busReq | output | 1 | Bus cycle requested |
| busAddr | output | ADDR_W | Bus cycle byte address |
| busByte | output | 1 | 1 = byte cycle, 0 = word cycle |
| busWrite | output | 1 | 1 = write cycle |
| busWdata | output | 16 | Write data; byte cycles use bits 7:0 |
| busAck | input | 1 | Cycle complete |
| busRdata | input | 16 | Read word, valid with busAck |
| busTimeout | input | 1 | Cycle failed; abort fragment |

## Verification
The assertions take it as given that busAck and busTimeout are raised only while busReq is high, and that each lasts a single clock. A fragment's reqLen must lie between 1 and 3. The bench's responder keeps to this: it reacts only to a pending request, waits a seeded random zero to three clocks, pulses one of the two inputs once, and then drops it. Fragments are drawn with lengths 1 to 3 only. Requests presented while busy arrive solely in the dedicated ignored-request cases.

// File: rtl/qfrag_pkg.sv
package qfrag_pkg;
  localparam int BUS_W = 16;
  localparam int WDATA_W = 24;
  localparam int RDATA_W = 2 * BUS_W;

  typedef struct packed {
    logic load;
    logic capture;
  } ctlStrobe_t;

  typedef struct packed {
    logic       isByte;
    logic [1:0] addrAdd;
    logic [1:0] lane;
  } cycPlan_t;

  function automatic logic needsTwo(input logic [1:0] len, input logic bit0,
                                    input logic write);
    if (!write) return ({1'b0, len} + {2'b00, bit0}) > 3'd2;
    case (len)
      2'd2:    return bit0;
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic cycPlan_t planOf(input logic [1:0] len, input logic bit0,
                                      input logic write, input logic idx);
    cycPlan_t p;
    p = '{isByte: 1'b1, addrAdd: 2'd0, lane: 2'd0};
    if (!write) begin
      p.isByte  = 1'b0;
      p.addrAdd = idx ? 2'd2 : 2'd0;
    end else begin
      case (len)
        2'd2: begin
          if (bit0) begin
            p.addrAdd = {1'b0, idx};
            p.lane    = {1'b0, idx};
          end else begin
            p.isByte = 1'b0;
          end
        end
        2'd3: begin
          if (bit0) begin
            p.isByte  = !idx;
            p.addrAdd = {1'b0, idx};
            p.lane    = {1'b0, idx};
          end else begin
            p.isByte  = idx;
            p.addrAdd = idx ? 2'd2 : 2'd0;
            p.lane    = idx ? 2'd2 : 2'd0;
          end
        end
        default: p.isByte = 1'b1;
      endcase
    end
    return p;
  endfunction
endpackage

// File: rtl/qfrag_ctl.sv
module qfrag_ctl
  import qfrag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       busAck,
  input  logic       busTimeout,
  input  logic       isLast,
  output ctlStrobe_t strobe,
  output logic       busReq,
  output logic       busy,
  output logic       doneStb,
  output logic       errStb
);
  typedef enum logic {ST_IDLE, ST_BUS} state_t;

  state_t stateQ;
  logic   doneQ;
  logic   errQ;

  always_comb begin
    strobe.load    = (stateQ == ST_IDLE) && reqValid;
    strobe.capture = (stateQ == ST_BUS) && busAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      case (stateQ)
        ST_IDLE: if (reqValid) stateQ <= ST_BUS;
        ST_BUS: begin
          if (busAck) begin
            if (isLast) begin
              stateQ <= ST_IDLE;
              doneQ  <= 1'b1;
            end
          end else if (busTimeout) begin
            stateQ <= ST_IDLE;
            errQ   <= 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busReq  = (stateQ == ST_BUS);
  assign busy    = (stateQ != ST_IDLE);
  assign doneStb = doneQ;
  assign errStb  = errQ;
endmodule

// File: rtl/qfrag_dp.sv
module qfrag_dp
  import qfrag_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqLen,
  input  logic               reqWrite,
  input  logic [WDATA_W-1:0] reqWdata,
  input  logic [BUS_W-1:0]   busRdata,
  output logic               isLast,
  output logic [ADDR_W-1:0]  busAddr,
  output logic               busByte,
  output logic               busWrite,
  output logic [BUS_W-1:0]   busWdata,
  output logic [RDATA_W-1:0] rdData
);
  logic [ADDR_W-1:0]  addrQ;
  logic [1:0]         lenQ;
  logic               writeQ;
  logic [WDATA_W-1:0] dataQ;
  logic               twoQ;
  logic               idxQ;
  logic [BUS_W-1:0]   firstQ;
  logic [RDATA_W-1:0] rdQ;

  cycPlan_t          plan;
  logic [ADDR_W-1:0] baseAddr;
  logic [BUS_W-1:0]  laneData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      lenQ   <= 2'd1;
      writeQ <= 1'b0;
      dataQ  <= '0;
      twoQ   <= 1'b0;
      idxQ   <= 1'b0;
      firstQ <= '0;
      rdQ    <= '0;
    end else if (strobe.load) begin
      addrQ  <= reqAddr;
      lenQ   <= reqLen;
      writeQ <= reqWrite;
      dataQ  <= reqWdata;
      twoQ   <= needsTwo(reqLen, reqAddr[0], reqWrite);
      idxQ   <= 1'b0;
    end else if (strobe.capture) begin
      idxQ <= 1'b1;
      if (!isLast) begin
        firstQ <= busRdata;
      end else if (!writeQ) begin
        if (twoQ)          rdQ <= {busRdata, firstQ};
        else if (addrQ[1]) rdQ <= {busRdata, {BUS_W{1'b0}}};
        else               rdQ <= {{BUS_W{1'b0}}, busRdata};
      end
    end
  end

  assign isLast = !twoQ || idxQ;

  always_comb begin
    plan     = planOf(lenQ, addrQ[0], writeQ, idxQ);
    baseAddr = writeQ ? addrQ : {addrQ[ADDR_W-1:1], 1'b0};
    case (plan.lane)
      2'd1:    laneData = dataQ[23:8];
      2'd2:    laneData = {8'h00, dataQ[23:16]};
      default: laneData = dataQ[15:0];
    endcase
  end

  assign busAddr  = baseAddr + {{(ADDR_W-2){1'b0}}, plan.addrAdd};
  assign busByte  = plan.isByte;
  assign busWrite = writeQ;
  assign busWdata = plan.isByte ? {8'h00, laneData[7:0]} : laneData;
  assign rdData   = rdQ;
endmodule

// File: rtl/qfrag_seq.sv
module qfrag_seq
  import qfrag_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [1:0]         reqLen,
  input  logic               reqWrite,
  input  logic [WDATA_W-1:0] reqWdata,
  output logic               busy,
  output logic               doneStb,
  output logic               errStb,
  output logic [RDATA_W-1:0] rdData,
  output logic               busReq,
  output logic [ADDR_W-1:0]  busAddr,
  output logic               busByte,
  output logic               busWrite,
  output logic [BUS_W-1:0]   busWdata,
  input  logic               busAck,
  input  logic [BUS_W-1:0]   busRdata,
  input  logic               busTimeout
);
  ctlStrobe_t strobe;
  logic       isLast;

  qfrag_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busAck(busAck),
    .busTimeout(busTimeout), .isLast(isLast), .strobe(strobe),
    .busReq(busReq), .busy(busy), .doneStb(doneStb), .errStb(errStb)
  );

  qfrag_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .busRdata(busRdata), .isLast(isLast), .busAddr(busAddr),
    .busByte(busByte), .busWrite(busWrite), .busWdata(busWdata),
    .rdData(rdData)
  );
endmodule

// File: rtl/qfrag_seq_chk.sv
module qfrag_seq_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              doneStb,
  input logic              errStb,
  input logic              busReq,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busByte,
  input logic              busWrite,
  input logic [15:0]       busWdata,
  input logic              busAck,
  input logic              busTimeout
);
  logic [1:0] ackCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                   ackCnt <= 2'd0;
    else if (reqValid && !busy)  ackCnt <= 2'd0;
    else if (busReq && busAck)   ackCnt <= ackCnt + 2'd1;
  end

  assert_idle_reset_R1: assert property (@(posedge clk)
    !rstN |=> !busy && !busReq && !doneStb && !errStb);

  assert_read_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busWrite |-> !busByte && !busAddr[0]);

  assert_word_even_R4: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busByte |-> !busAddr[0]);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck && !busTimeout |=> busReq && $stable(busAddr) &&
    $stable(busByte) && $stable(busWrite) && $stable(busWdata));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

  assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> $past(busAck) && !busy);

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    errStb |-> !busReq && !doneStb && $past(busTimeout));

  assert_cycle_limit_R12: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck |-> ackCnt < 2'd2);
endmodule

bind qfrag_seq qfrag_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy),
  .doneStb(doneStb), .errStb(errStb), .busReq(busReq), .busAddr(busAddr),
  .busByte(busByte), .busWrite(busWrite), .busWdata(busWdata),
  .busAck(busAck), .busTimeout(busTimeout)
);

// File: tb/qfrag_seq_tb.sv
`timescale 1ns/1ps
module qfrag_seq_tb;
  localparam int AW = 22;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqLen = 2'd1;
  logic          reqWrite = 1'b0;
  logic [23:0]   reqWdata = '0;
  logic          busy, doneStb, errStb, busReq, busByte, busWrite;
  logic [31:0]   rdData;
  logic [AW-1:0] busAddr;
  logic [15:0]   busWdata;
  logic          busAck = 1'b0;
  logic [15:0]   busRdata = '0;
  logic          busTimeout = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  qfrag_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .busy(busy), .doneStb(doneStb), .errStb(errStb), .rdData(rdData),
    .busReq(busReq), .busAddr(busAddr), .busByte(busByte),
    .busWrite(busWrite), .busWdata(busWdata), .busAck(busAck),
    .busRdata(busRdata), .busTimeout(busTimeout)
  );

  // bus responder log
  logic [AW-1:0] logAddr [8];
  logic          logByte [8];
  logic          logWr   [8];
  logic [15:0]   logData [8];
  int logN = 0;
  int negCnt = 0;
  int ackNeg = 0;
  int holdErr = 0;
  bit toMode = 0;
  bit pend = 0;
  int waitCnt = 0;

  function automatic logic [15:0] rdFor(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[8:1]};
  endfunction

  always @(negedge clk) begin
    negCnt++;
    if (busAck || busTimeout) begin
      busAck = 1'b0;
      busTimeout = 1'b0;
    end else if (busReq && !pend) begin
      if (logN < 8) begin
        logAddr[logN] = busAddr;
        logByte[logN] = busByte;
        logWr[logN]   = busWrite;
        logData[logN] = busWdata;
      end
      logN++;
      pend = 1;
      waitCnt = int'($urandom % 4);
    end else if (pend) begin
      if (!busReq) holdErr++;
      if (waitCnt == 0) begin
        if (toMode) busTimeout = 1'b1;
        else begin
          busAck = 1'b1;
          busRdata = rdFor(busAddr);
        end
        pend = 0;
        ackNeg = negCnt;
      end else waitCnt--;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // expected cycle list
  int            eN;
  logic [AW-1:0] eAddr [2];
  logic          eByte [2];
  logic [15:0]   eData [2];
  logic [31:0]   eRd;
  string         eTag;

  task automatic buildExp(input logic [AW-1:0] a, input logic [1:0] l,
                          input logic w, input logic [23:0] d);
    logic [AW-1:0] ev;
    ev = {a[AW-1:1], 1'b0};
    eData[0] = 16'h0; eData[1] = 16'h0; eRd = 32'h0;
    if (!w) begin
      eByte[0] = 0; eByte[1] = 0;
      eAddr[0] = ev; eAddr[1] = ev + 2;
      if (int'(l) + int'(a[0]) <= 2) begin
        eN = 1; eTag = "R2";
        eRd = a[1] ? {rdFor(ev), 16'h0} : {16'h0, rdFor(ev)};
      end else begin
        eN = 2; eTag = "R3";
        eRd = {rdFor(ev + 2), rdFor(ev)};
      end
    end else if (l == 2'd1) begin
      eN = 1; eTag = "R5";
      eAddr[0] = a; eByte[0] = 1; eData[0] = {8'h0, d[7:0]};
    end else if (l == 2'd2) begin
      eTag = "R6";
      if (a[0]) begin
        eN = 2;
        eAddr[0] = a;     eByte[0] = 1; eData[0] = {8'h0, d[7:0]};
        eAddr[1] = a + 1; eByte[1] = 1; eData[1] = {8'h0, d[15:8]};
      end else begin
        eN = 1;
        eAddr[0] = a; eByte[0] = 0; eData[0] = d[15:0];
      end
    end else if (a[0]) begin
      eN = 2; eTag = "R7";
      eAddr[0] = a;     eByte[0] = 1; eData[0] = {8'h0, d[7:0]};
      eAddr[1] = a + 1; eByte[1] = 0; eData[1] = d[23:8];
    end else begin
      eN = 2; eTag = "R8";
      eAddr[0] = a;     eByte[0] = 0; eData[0] = d[15:0];
      eAddr[1] = a + 2; eByte[1] = 1; eData[1] = {8'h0, d[23:16]};
    end
  endtask

  task automatic runOne(input logic [AW-1:0] a, input logic [1:0] l,
                        input logic w, input logic [23:0] d, input bit poke);
    bit seenDone, seenErr;
    int doneAt, logBefore;
    buildExp(a, l, w, d);
    logN = 0; holdErr = 0;
    seenDone = 0; seenErr = 0; doneAt = 0;
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqLen = l; reqWrite = w; reqWdata = d;
    @(negedge clk);
    reqValid = 0;
    if (poke) begin
      reqValid = 1; reqAddr = a ^ 22'h0155; reqLen = 2'd3;
      reqWrite = ~w; reqWdata = ~d;
      @(negedge clk);
      reqValid = 0;
    end
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      if (doneStb || errStb) begin
        seenDone = doneStb; seenErr = errStb; doneAt = negCnt;
        break;
      end
    end
    chk(seenDone && !seenErr, "R10", "done strobe seen", seenDone, 1);
    chk(doneAt == ackNeg + 1, "R10", "done one clock after final ack",
        doneAt, ackNeg + 1);
    chk(logN == eN, eTag, "cycle count", logN, eN);
    for (int k = 0; k < 2; k++) begin
      if (k < eN && k < logN) begin
        chk(logAddr[k] == eAddr[k], eTag, $sformatf("cycle %0d addr", k),
            logAddr[k], eAddr[k]);
        chk(logByte[k] == eByte[k], w ? eTag : "R4",
            $sformatf("cycle %0d byte select", k), logByte[k], eByte[k]);
        chk(logWr[k] == w, eTag, $sformatf("cycle %0d direction", k),
            logWr[k], w);
        if (w) chk(logData[k] == eData[k], eTag,
                   $sformatf("cycle %0d data", k), logData[k], eData[k]);
      end
    end
    if (!w) chk(rdData == eRd, eTag, "read result", rdData, eRd);
    chk(holdErr == 0, "R9", "request held until ack", holdErr, 0);
    logBefore = logN;
    repeat (3) @(negedge clk);
    #1;
    chk(!busReq && !busy && logN == logBefore, "R12",
        "no extra cycles after fragment", logN, logBefore);
  endtask

  task automatic runTimeout(input logic [AW-1:0] a, input logic [1:0] l,
                            input logic w);
    bit seenDone, seenErr;
    logN = 0; seenDone = 0; seenErr = 0;
    toMode = 1;
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqLen = l; reqWrite = w; reqWdata = 24'hABCDEF;
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      if (doneStb) seenDone = 1;
      if (errStb) seenErr = 1;
    end
    toMode = 0;
    chk(seenErr, "R11", "error strobe on timeout", seenErr, 1);
    chk(!seenDone, "R11", "no done after timeout", seenDone, 0);
    chk(logN == 1, "R11", "no cycle after timeout", logN, 1);
    chk(!busReq && !busy, "R11", "idle after abort", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0051_ED01));
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !busReq && !doneStb && !errStb, "R1", "reset outputs idle",
        {busy, busReq, doneStb, errStb}, 0);
    @(negedge clk);
    rstN = 1;
    #1;
    chk(!busy && !busReq, "R1", "idle after reset release", busy, 0);

    // directed: every offset, length and direction
    for (int w = 0; w < 2; w++)
      for (int l = 1; l < 4; l++)
        for (int o = 0; o < 4; o++)
          runOne(22'h01A3C0 | AW'(o), 2'(l), 1'(w), 24'hC3A596, 1'b0);

    // ignored requests while busy
    runOne(22'h000101, 2'd3, 1'b1, 24'h123456, 1'b1);
    runOne(22'h000202, 2'd1, 1'b0, 24'h0, 1'b1);

    // timeouts on first cycle
    runTimeout(22'h000011, 2'd2, 1'b1);
    runTimeout(22'h000031, 2'd3, 1'b0);

    // address wrap at the top
    runOne({AW{1'b1}}, 2'd2, 1'b1, 24'h00BEEF, 1'b0);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] ra;
      logic [1:0]    rl;
      ra = AW'($urandom);
      rl = 2'($urandom % 3 + 1);
      runOne(ra, rl, 1'($urandom), 24'($urandom), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule